// File: doc/BRIEF.md
# Programmable DMA Transfer Byte Counter

This block tracks how many bytes a SCSI protocol controller still has to move over DMA. Software stages the transfer length in byte-wide holding registers. When a command carrying the DMA enable flag (bit 7 of the command code) is issued, the staged value is copied into a working down-counter. Each byte the DMA engine moves pulses a decrement strobe, and a zero flag tells the status logic when the transfer length is used up.

The counter works in one of two widths, chosen at load time by a mode input. The narrow width is 16 bits and uses the low and middle bytes. The wide width is 24 bits and adds the high byte. A staged length of zero means the largest count the chosen width allows, so the counter then holds one more than its byte registers can show.

Reads at the low and middle addresses return the live count. A read at the high-byte address returns a fixed identification byte instead of the count.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset the live count is 0, the zero flag is 1, and reads at address 0 and address 1 return 0x00.
- R2: A register write stores a byte in a holding register only. The live count does not change until the next load.
- R3: A load happens only when cmd_wr is high and bit 7 of cmd_code is 1. A command with bit 7 clear leaves the live count as it was.
- R4: With wide_mode low at load, the count becomes (byte at address 1)·256 + (byte at address 0). The byte at address 2 is ignored.
- R5: With wide_mode high at load, the count becomes (address 2)·65536 + (address 1)·256 + (address 0). The width is fixed at load, so later changes of wide_mode do not alter the live count.
- R6: A staged value of zero loads 65536 in narrow mode and 16777216 in wide mode. The zero flag is clear after every load.
- R7: Each cycle with byte_dec high and a non-zero count lowers the count by exactly one. Address 0 reads bits 7:0 of the live count and address 1 reads bits 15:8.
- R8: At zero, further decrements are ignored. The count stays 0 and the zero flag stays 1 until the next load.
- R9: A read at address 2 returns the identification byte, with the family code in bits 7:3 and the revision in bits 2:0 (0x11 by default). Address 3 reads 0x00.
- R10: When a load and a decrement occur in the same cycle, the load wins and the count equals the loaded value.
- R11: cnt_zero is 1 exactly when the live count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe for the holding registers |
| reg_addr | input | 2 | Byte address for writes and reads (0 low, 1 middle, 2 high/identification) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cmd_wr | input | 1 | Command issue strobe |
| cmd_code | input | 8 | Command code; bit 7 requests a counter load |
| byte_dec | input | 1 | One pulse per byte moved by DMA |
| wide_mode | input | 1 | 1 selects 24-bit counting and 0 selects 16-bit counting, sampled at load |
| cnt_zero | output | 1 | Transfer count has reached zero |
| cnt_live | output | 25 | Live working count |

## Verification
Loads, decrements and the zero flag all change on the single clock edge that samples the strobe. Their effects show on cnt_live, cnt_zero and reg_rdata one edge after the strobe is driven. Reads at a given address are combinational and show within the same cycle. The bench changes inputs on the falling edge and keeps each strobe high for exactly one rising edge. It samples results at the following falling edge, and reads settle one time unit after the address is driven.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int BYTE_W = 8;

  // identification byte: family code above, revision below
  function automatic logic [7:0] make_id(input logic [4:0] family, input logic [2:0] rev);
    return {family, rev};
  endfunction
endpackage

// File: rtl/xbc_hold_regs.sv
module xbc_hold_regs #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int ADDR_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [BYTE_W-1:0]                  wr_data,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0]   hold_o
);
  logic [NUM_BYTES-1:0] byte_we;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_comb byte_we[g] = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold_o[g] <= '0;
      else if (byte_we[g]) hold_o[g] <= wr_data;
    end
  end
endmodule

// File: rtl/xbc_load_calc.sv
module xbc_load_calc #(
  parameter int BYTE_W       = 8,
  parameter int NUM_BYTES    = 3,
  parameter int NARROW_BYTES = 2,
  localparam int RAW_W       = BYTE_W * NUM_BYTES,
  localparam int CNT_W       = RAW_W + 1
) (
  input  logic [NUM_BYTES-1:0][BYTE_W-1:0] hold_i,
  input  logic                             wide_i,
  output logic [CNT_W-1:0]                 load_val_o
);
  localparam int NARROW_W = BYTE_W * NARROW_BYTES;

  logic [RAW_W-1:0] raw;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_asm
    if (g < NARROW_BYTES) begin : g_always
      assign raw[g*BYTE_W +: BYTE_W] = hold_i[g];
    end else begin : g_wide_only
      assign raw[g*BYTE_W +: BYTE_W] = wide_i ? hold_i[g] : '0;
    end
  end

  // a staged zero stands for the full range of the selected width
  always_comb begin
    if (raw == '0) begin
      load_val_o = wide_i ? (CNT_W'(1) << RAW_W) : (CNT_W'(1) << NARROW_W);
    end else begin
      load_val_o = {1'b0, raw};
    end
  end
endmodule

// File: rtl/xbc_down_core.sv
module xbc_down_core #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_d;
  logic             zero_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_o;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = load_val_i;
      cnt_en = 1'b1;
    end else if (dec_i && !zero_o) begin
      cnt_d  = cnt_o - CNT_W'(1);
      cnt_en = 1'b1;
    end
    zero_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      zero_o <= 1'b1;
    end else if (cnt_en) begin
      cnt_o  <= cnt_d;
      zero_o <= zero_d;
    end
  end
endmodule

// File: rtl/xbc_read_mux.sv
module xbc_read_mux #(
  parameter int          BYTE_W    = 8,
  parameter int          NUM_BYTES = 3,
  parameter int          ADDR_W    = 2,
  parameter int          CNT_W     = 25,
  parameter logic [7:0]  ID_CODE   = 8'h11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BYTES - 1; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = cnt_i[i*BYTE_W +: BYTE_W];
    end
    if (addr_i == ADDR_W'(NUM_BYTES - 1)) rdata_o = BYTE_W'(ID_CODE);
  end
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter #(
  parameter int         NUM_BYTES    = 3,
  parameter int         NARROW_BYTES = 2,
  parameter logic [4:0] FAMILY_CODE  = 5'd2,
  parameter logic [2:0] REVISION     = 3'd1,
  localparam int        BYTE_W       = xbc_pkg::BYTE_W,
  localparam int        ADDR_W       = $clog2(NUM_BYTES + 1),
  localparam int        CNT_W        = BYTE_W * NUM_BYTES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_code,
  input  logic              byte_dec,
  input  logic              wide_mode,
  output logic              cnt_zero,
  output logic [CNT_W-1:0]  cnt_live
);
  localparam logic [7:0] ID_CODE = xbc_pkg::make_id(FAMILY_CODE, REVISION);

  logic [1:0]                       rst_pipe;
  logic                             rst_n_sync;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] hold;
  logic [CNT_W-1:0]                 load_val;
  logic                             load_req;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  assign load_req = cmd_wr && cmd_code[BYTE_W-1];

  xbc_hold_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .hold_o  (hold)
  );

  xbc_load_calc #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .NARROW_BYTES(NARROW_BYTES)) u_calc (
    .hold_i     (hold),
    .wide_i     (wide_mode),
    .load_val_o (load_val)
  );

  xbc_down_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .load_i     (load_req),
    .load_val_i (load_val),
    .dec_i      (byte_dec),
    .cnt_o      (cnt_live),
    .zero_o     (cnt_zero)
  );

  xbc_read_mux #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W),
                 .CNT_W(CNT_W), .ID_CODE(ID_CODE)) u_rd (
    .addr_i  (reg_addr),
    .cnt_i   (cnt_live),
    .rdata_o (reg_rdata)
  );
endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int         CNT_W   = 25,
  parameter int         ADDR_W  = 2,
  parameter int         BYTE_W  = 8,
  parameter int         HI_ADDR = 2,
  parameter logic [7:0] ID_CODE = 8'h11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              cmd_wr,
  input logic [BYTE_W-1:0] cmd_code,
  input logic              byte_dec,
  input logic              cnt_zero,
  input logic [CNT_W-1:0]  cnt_live
);
  logic load_seen;
  assign load_seen = cmd_wr && cmd_code[BYTE_W-1];

  p_quiet_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_seen && !byte_dec) |=> $stable(cnt_live));

  p_load_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_seen |=> (cnt_live != '0) && !cnt_zero);

  p_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_live <= (CNT_W'(1) << (CNT_W - 1)));

  p_dec_by_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_dec && !load_seen && cnt_live != '0) |=> cnt_live == $past(cnt_live) - CNT_W'(1));

  p_stop_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_live == '0 && !load_seen) |=> (cnt_live == '0) && cnt_zero);

  p_id_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(HI_ADDR)) |-> reg_rdata == BYTE_W'(ID_CODE));

  p_zero_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero == (cnt_live == '0));
endmodule

bind xfer_byte_counter xbc_checker #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
  .HI_ADDR(NUM_BYTES - 1), .ID_CODE(ID_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .cmd_wr    (cmd_wr),
  .cmd_code  (cmd_code),
  .byte_dec  (byte_dec),
  .cnt_zero  (cnt_zero),
  .cnt_live  (cnt_live)
);

// File: tb/xfer_byte_counter_test.sv
module xfer_byte_counter_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        cmd_wr;
  logic [7:0]  cmd_code;
  logic        byte_dec;
  logic        wide_mode;
  logic        cnt_zero;
  logic [24:0] cnt_live;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  xfer_byte_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
    .cmd_code(cmd_code), .byte_dec(byte_dec), .wide_mode(wide_mode),
    .cnt_zero(cnt_zero), .cnt_live(cnt_live)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic issue(input logic [7:0] code);
    cmd_wr = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_code = 8'h00;
  endtask

  task automatic dec(input int n);
    byte_dec = 1'b1;
    repeat (n) @(negedge clk);
    byte_dec = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic stage(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
    wr(2'd0, lo); wr(2'd1, mid); wr(2'd2, hi);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 count", cnt_live, 0);
    chk("R1 zero flag", cnt_zero, 1);
    rd(2'd0, d); chk("R1 read lo", d, 0);
    rd(2'd1, d); chk("R1 read mid", d, 0);
  endtask

  task automatic t_write_only;
    stage(8'h34, 8'h12, 8'h56);
    chk("R2 count after writes", cnt_live, 0);
    chk("R2 zero after writes", cnt_zero, 1);
  endtask

  task automatic t_non_dma_cmd;
    issue(8'h11);
    chk("R3 non-DMA command", cnt_live, 0);
  endtask

  task automatic t_narrow_load;
    logic [7:0] d;
    wide_mode = 1'b0;
    issue(8'h90);
    chk("R4 narrow load ignores high", cnt_live, 32'h1234);
    chk("R11 flag after load", cnt_zero, 0);
    rd(2'd0, d); chk("R7 read lo", d, 8'h34);
    rd(2'd1, d); chk("R7 read mid", d, 8'h12);
  endtask

  task automatic t_wide_load;
    wide_mode = 1'b1;
    issue(8'h80);
    chk("R5 wide load", cnt_live, 32'h561234);
    wide_mode = 1'b0;
    @(negedge clk);
    chk("R5 mode change after load", cnt_live, 32'h561234);
    stage(8'h00, 8'h00, 8'h01);
    wide_mode = 1'b1;
    issue(8'h80);
    chk("R5 wide high byte only", cnt_live, 32'h010000);
  endtask

  task automatic t_zero_is_max;
    logic [7:0] d;
    stage(8'h00, 8'h00, 8'h77);
    wide_mode = 1'b0;
    issue(8'h80);
    chk("R6 narrow zero load", cnt_live, 32'h10000);
    chk("R6 flag clear", cnt_zero, 0);
    rd(2'd0, d); chk("R7 lo of 65536", d, 0);
    dec(1);
    chk("R7 65536 minus one", cnt_live, 32'hFFFF);
    wr(2'd2, 8'h00);
    wide_mode = 1'b1;
    issue(8'h80);
    chk("R6 wide zero load", cnt_live, 32'h1000000);
    chk("R6 wide flag clear", cnt_zero, 0);
    wide_mode = 1'b0;
  endtask

  task automatic t_decrement;
    logic [7:0] d;
    stage(8'h05, 8'h01, 8'h00);
    issue(8'h80);
    dec(3);
    chk("R7 three decrements", cnt_live, 32'h0102);
    stage(8'h00, 8'h01, 8'h00);
    issue(8'h80);
    dec(1);
    chk("R7 borrow across byte", cnt_live, 32'h00FF);
    rd(2'd0, d); chk("R7 lo after borrow", d, 8'hFF);
    rd(2'd1, d); chk("R7 mid after borrow", d, 8'h00);
  endtask

  task automatic t_stop_at_zero;
    stage(8'h02, 8'h00, 8'h00);
    issue(8'h80);
    dec(2);
    chk("R8 reaches zero", cnt_live, 0);
    chk("R11 flag at zero", cnt_zero, 1);
    dec(3);
    chk("R8 held at zero", cnt_live, 0);
    chk("R8 flag held", cnt_zero, 1);
    issue(8'h80);
    chk("R8 reload", cnt_live, 2);
    chk("R8 flag cleared by load", cnt_zero, 0);
  endtask

  task automatic t_priority;
    stage(8'h05, 8'h00, 8'h00);
    byte_dec = 1'b1;
    cmd_wr = 1'b1; cmd_code = 8'h80;
    @(negedge clk);
    cmd_wr = 1'b0; byte_dec = 1'b0;
    chk("R10 load beats decrement", cnt_live, 5);
  endtask

  task automatic t_id_read;
    logic [7:0] d;
    rd(2'd2, d); chk("R9 id byte", d, 8'h11);
    rd(2'd3, d); chk("R9 unused address", d, 8'h00);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    cmd_wr = 1'b0; cmd_code = 8'h00; byte_dec = 1'b0; wide_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_only();
    t_non_dma_cmd();
    t_narrow_load();
    t_wide_load();
    t_zero_is_max();
    t_decrement();
    t_stop_at_zero();
    t_priority();
    t_id_read();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule